// File: doc/BRIEF.md
# Flash Microcode Bytecode Engine

This block is a small sequencer that runs a bytecode program which drives a flash controller. The program is a list of 64-bit instructions read through a dedicated fetch port. The engine holds eight 32-bit general registers. It reaches two data spaces. The first is system RAM, addressed by full 32-bit pointers held in registers. The second is a peripheral window, addressed by a 16-bit offset added to a fixed base address. The engine can also stall on one bit of an 8-bit status word, so the program can wait for a controller event.

A host pulses `start` while the engine is idle. The engine then runs from bytecode offset zero until it meets a halt instruction or an opcode it does not know. At that point it pulses `done` for one cycle. An unknown opcode also sets `error`, which stays set until the next launch.

Each instruction in storage is two 32-bit words. The word in the upper half of the fetch bus has its bytes reversed. Once decoded, the instruction holds, from most significant bit down: an 8-bit opcode, an 8-bit destination register field, a 16-bit field that names a source register or gives a window offset, and a 32-bit immediate. Every data access, and every fetch, uses a valid/ready handshake. An instruction retires only once the ready signal has been seen.

Top module: `flash_bytecode_engine`

## Requirements
- R1: After reset, `busy`, `done` and `error` are 0 and no request is raised. A `start` pulse in idle begins fetching at byte offset 0. Each instruction that does not jump moves the program counter forward by 8. Every fetch address is a multiple of 8.
- R2: Fetch data encoding. Bits [31:0] of `fetch_data` are the immediate. Bits [63:32] are a word W with its bytes reversed: opcode = W[7:0], destination = W[15:8], and the 16-bit field = {W[23:16], W[31:24]}. Register fields use only their low 3 bits, so destination field 0x09 names r1 and field 0x0008 names r0.
- R3: Opcode 0x00 halts the engine. `done` is high for exactly one cycle and `busy` drops.
- R4: Opcode 0x05 loads the immediate into the destination register. Opcode 0x06 copies the source register into the destination register.
- R5: Opcodes 0x0A AND, 0x0B OR, 0x0C ADD, 0x0D SUB, 0x13 shift left and 0x14 shift right each have two forms. With an immediate of 0 the result is dest = dest op src. Otherwise the result is dest = src op imm. Right shifts are logical. A shift amount uses only its low 5 bits.
- R6: Opcode 0x0E jumps when the destination register is nonzero, and opcode 0x17 jumps when it is zero. The jump target is the immediate, taken as an absolute byte offset. When the condition fails, execution falls through to the next instruction.
- R7: The window address is BASE (default 0x38A00000) plus a 16-bit offset. Opcode 0x01 writes the immediate at the 16-bit field offset. Opcode 0x02 writes the destination register at that offset. Opcode 0x04 loads the destination register from that offset, ANDed with the immediate. Opcodes 0x18 (load) and 0x19 (store) move the destination register to or from the offset given by the low 16 bits of the source register.
- R8: Opcode 0x03 loads the destination register from the RAM address held in the source register. Opcode 0x11 stores the source register to the RAM address held in the destination register.
- R9: At most one of the fetch, RAM and window requests is high at a time. A request, with its address, is held until ready. The instruction retires only after ready, so results are the same for any ready latency.
- R10: Opcode 0x07 stalls until `status[dest[2:0]]` is 1. Other status bits have no effect on it.
- R11: An undefined opcode halts the engine with a one-cycle `done` pulse and sets `error`. No later instruction runs. A new `start` clears `error`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch the program at offset 0 (taken while idle) |
| busy | output | 1 | Engine is running |
| done | output | 1 | One-cycle pulse on halt |
| error | output | 1 | Last run ended on an undefined opcode |
| fetch_req | output | 1 | Instruction fetch request |
| fetch_addr | output | 32 | Byte offset of the instruction |
| fetch_data | input | 64 | Instruction in storage byte order |
| fetch_ready | input | 1 | Fetch data valid |
| ram_req | output | 1 | RAM access request |
| ram_we | output | 1 | RAM write when 1, read when 0 |
| ram_addr | output | 32 | RAM byte address |
| ram_wdata | output | 32 | RAM write data |
| ram_rdata | input | 32 | RAM read data |
| ram_ready | input | 1 | RAM access complete |
| win_req | output | 1 | Window access request |
| win_we | output | 1 | Window write when 1, read when 0 |
| win_addr | output | 32 | Window byte address (base plus offset) |
| win_wdata | output | 32 | Window write data |
| win_rdata | input | 32 | Window read data |
| win_ready | input | 1 | Window access complete |
| status | input | 8 | Controller status bits for the wait opcode |

## Verification
The embedded assertions check every cycle that requests are mutually exclusive and stay steady until ready, that fetch addresses are aligned, that the engine is quiet while idle, that `done` lasts one cycle, and that `error` only appears together with `done`. Data results cannot be seen by a property. These include each ALU form, masked and indirect window accesses, the RAM pointer paths, jump targets, the status bit selection and the skipping of instructions after an undefined opcode. Only the bench's directed programs show them, by reading back what each program leaves in its model memories.

// File: rtl/flash_bytecode_engine.sv
module flash_bytecode_engine #(
  parameter logic [31:0] BASE = 32'h38A0_0000,
  parameter int          NREG = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output logic        busy,
  output logic        done,
  output logic        error,
  output logic        fetch_req,
  output logic [31:0] fetch_addr,
  input  logic [63:0] fetch_data,
  input  logic        fetch_ready,
  output logic        ram_req,
  output logic        ram_we,
  output logic [31:0] ram_addr,
  output logic [31:0] ram_wdata,
  input  logic [31:0] ram_rdata,
  input  logic        ram_ready,
  output logic        win_req,
  output logic        win_we,
  output logic [31:0] win_addr,
  output logic [31:0] win_wdata,
  input  logic [31:0] win_rdata,
  input  logic        win_ready,
  input  logic [7:0]  status
);
  localparam int RW = $clog2(NREG);

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_EXEC, S_MEM, S_WAIT} state_t;
  state_t state;

  logic [31:0]   regs [NREG];
  logic [31:0]   pc, imm_q, rdv, rsv, opa, opb, alu_res, ld_res, pc_next;
  logic [7:0]    op_q;
  logic [RW-1:0] rd_q;
  logic [15:0]   fld_q, win_off;
  logic          two_reg, is_win, is_ram, mem_ok;

  assign rdv      = regs[rd_q];
  assign rsv      = regs[fld_q[RW-1:0]];
  assign two_reg  = (imm_q == 32'd0);
  assign opa      = two_reg ? rdv : rsv;
  assign opb      = two_reg ? rsv : imm_q;
  assign pc_next  = pc + 32'd8;

  always_comb begin
    case (op_q)
      8'h05:   alu_res = imm_q;
      8'h06:   alu_res = rsv;
      8'h0A:   alu_res = opa & opb;
      8'h0B:   alu_res = opa | opb;
      8'h0C:   alu_res = opa + opb;
      8'h0D:   alu_res = opa - opb;
      8'h13:   alu_res = opa << opb[4:0];
      8'h14:   alu_res = opa >> opb[4:0];
      default: alu_res = 32'd0;
    endcase
  end

  assign is_win = (op_q == 8'h01) || (op_q == 8'h02) || (op_q == 8'h04) ||
                  (op_q == 8'h18) || (op_q == 8'h19);
  assign is_ram = (op_q == 8'h03) || (op_q == 8'h11);

  assign win_off   = (op_q == 8'h18 || op_q == 8'h19) ? rsv[15:0] : fld_q;
  assign win_req   = (state == S_MEM) && is_win;
  assign win_we    = (op_q == 8'h01) || (op_q == 8'h02) || (op_q == 8'h19);
  assign win_addr  = BASE + {16'd0, win_off};
  assign win_wdata = (op_q == 8'h01) ? imm_q : rdv;

  assign ram_req   = (state == S_MEM) && is_ram;
  assign ram_we    = (op_q == 8'h11);
  assign ram_addr  = (op_q == 8'h03) ? rsv : rdv;
  assign ram_wdata = rsv;

  assign ld_res = (op_q == 8'h03) ? ram_rdata :
                  (op_q == 8'h04) ? (win_rdata & imm_q) : win_rdata;
  assign mem_ok = (win_req && win_ready) || (ram_req && ram_ready);

  assign fetch_req  = (state == S_FETCH);
  assign fetch_addr = pc;
  assign busy       = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      pc    <= '0;
      op_q  <= '0;
      rd_q  <= '0;
      fld_q <= '0;
      imm_q <= '0;
      done  <= 1'b0;
      error <= 1'b0;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          pc    <= '0;
          error <= 1'b0;
          state <= S_FETCH;
        end
        S_FETCH: if (fetch_ready) begin
          op_q  <= fetch_data[39:32];
          rd_q  <= fetch_data[40 +: RW];
          fld_q <= {fetch_data[55:48], fetch_data[63:56]};
          imm_q <= fetch_data[31:0];
          state <= S_EXEC;
        end
        S_EXEC: begin
          case (op_q)
            8'h00: begin
              done  <= 1'b1;
              state <= S_IDLE;
            end
            8'h05, 8'h06, 8'h0A, 8'h0B, 8'h0C, 8'h0D, 8'h13, 8'h14: begin
              regs[rd_q] <= alu_res;
              pc         <= pc_next;
              state      <= S_FETCH;
            end
            8'h0E: begin
              pc    <= (rdv != 32'd0) ? imm_q : pc_next;
              state <= S_FETCH;
            end
            8'h17: begin
              pc    <= (rdv == 32'd0) ? imm_q : pc_next;
              state <= S_FETCH;
            end
            8'h01, 8'h02, 8'h03, 8'h04, 8'h11, 8'h18, 8'h19: state <= S_MEM;
            8'h07: state <= S_WAIT;
            default: begin
              error <= 1'b1;
              done  <= 1'b1;
              state <= S_IDLE;
            end
          endcase
        end
        S_MEM: if (mem_ok) begin
          if (!(is_win ? win_we : ram_we)) regs[rd_q] <= ld_res;
          pc    <= pc_next;
          state <= S_FETCH;
        end
        S_WAIT: if (status[rd_q]) begin
          pc    <= pc_next;
          state <= S_FETCH;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_one_request: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fetch_req, ram_req, win_req}));

  a_r9_win_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (win_req && !win_ready) |=> (win_req && $stable(win_addr) && $stable(win_we)));

  a_r9_ram_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_req && !ram_ready) |=> (ram_req && $stable(ram_addr) && $stable(ram_we)));

  a_r1_fetch_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> (fetch_addr[2:0] == 3'd0));

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(fetch_req || ram_req || win_req));

  a_r11_error_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> done);
endmodule

// File: tb/flash_bytecode_engine_test.sv
module flash_bytecode_engine_test;
  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic        busy, done, error;
  logic        fetch_req, fetch_ready, ram_req, ram_we, ram_ready, win_req, win_we, win_ready;
  logic [31:0] fetch_addr, ram_addr, ram_wdata, ram_rdata, win_addr, win_wdata, win_rdata;
  logic [63:0] fetch_data;
  logic [7:0]  status = 8'h00;

  logic [63:0] prog [64];
  logic [31:0] wmem [1024];
  logic [31:0] rmem [64];
  logic [3:0]  stall = 4'd0, f_cnt = 4'd0, r_cnt = 4'd0, w_cnt = 4'd0;
  logic [31:0] win_off, last_ram_addr = 32'd0;
  logic        bad_base = 1'b0;
  int          nfetch = 0, max_fetch = 0, cyc = 0;
  int          checks = 0, failures = 0;

  flash_bytecode_engine uut (.*);

  always #4 clk = ~clk;

  function automatic logic [63:0] enc(input logic [63:0] x);
    return {x[39:32], x[47:40], x[55:48], x[63:56], x[31:0]};
  endfunction

  function automatic logic [63:0] ins(input logic [7:0] op, input logic [7:0] d,
                                      input logic [15:0] f, input logic [31:0] im);
    return {op, d, f, im};
  endfunction

  assign win_off     = win_addr - 32'h38A0_0000;
  assign fetch_ready = fetch_req && (f_cnt >= stall);
  assign ram_ready   = ram_req && (r_cnt >= stall);
  assign win_ready   = win_req && (w_cnt >= stall);
  assign fetch_data  = enc(prog[fetch_addr[8:3]]);
  assign ram_rdata   = rmem[ram_addr[7:2]];
  assign win_rdata   = wmem[win_off[11:2]];

  always @(posedge clk) begin
    f_cnt <= (fetch_req && !fetch_ready) ? f_cnt + 4'd1 : 4'd0;
    r_cnt <= (ram_req && !ram_ready) ? r_cnt + 4'd1 : 4'd0;
    w_cnt <= (win_req && !win_ready) ? w_cnt + 4'd1 : 4'd0;
    if (win_req && win_ready && win_we) wmem[win_off[11:2]] <= win_wdata;
    if (ram_req && ram_ready && ram_we) begin
      rmem[ram_addr[7:2]] <= ram_wdata;
      last_ram_addr <= ram_addr;
    end
    if (win_req && win_addr[31:16] != 16'h38A0) bad_base <= 1'b1;
    if (fetch_req && fetch_ready) begin
      nfetch <= nfetch + 1;
      if (int'(fetch_addr) > max_fetch) max_fetch <= int'(fetch_addr);
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks = checks + 1;
    if (got !== exp) begin
      failures = failures + 1;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic clear_all();
    for (int i = 0; i < 64; i++) begin prog[i] = 64'd0; rmem[i] = 32'd0; end
    for (int i = 0; i < 1024; i++) wmem[i] = 32'd0;
  endtask

  task automatic launch();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic finish_run(input string tag);
    bit seen = 0;
    for (int i = 0; i < 2000; i++) begin
      if (done) begin seen = 1; break; end
      @(negedge clk);
    end
    check({tag, " R3 done seen"}, {31'd0, seen}, 32'd1);
    @(negedge clk);
    check({tag, " R3 done single cycle"}, {31'd0, done}, 32'd0);
    check({tag, " R3 busy dropped"}, {31'd0, busy}, 32'd0);
  endtask

  task automatic t_reset();
    check("R1 reset busy", {31'd0, busy}, 32'd0);
    check("R1 reset done", {31'd0, done}, 32'd0);
    check("R1 reset error", {31'd0, error}, 32'd0);
    check("R1 reset quiet", {29'd0, fetch_req, ram_req, win_req}, 32'd0);
  endtask

  task automatic t_basic();
    clear_all();
    prog[0] = ins(8'h05, 8'h00, 16'h0000, 32'h0000_6968);
    prog[1] = ins(8'h06, 8'h09, 16'h0008, 32'h0);
    prog[2] = ins(8'h02, 8'h01, 16'h0D10, 32'h0);
    prog[3] = ins(8'h01, 8'h00, 16'h0030, 32'h0000_01FF);
    nfetch = 0; max_fetch = 0;
    launch();
    check("R1 first fetch offset zero", fetch_addr, 32'd0);
    finish_run("basic");
    check("R4 R2 copy via low-3-bit fields", wmem[32'hD10 >> 2], 32'h0000_6968);
    check("R7 immediate write", wmem[32'h30 >> 2], 32'h0000_01FF);
    check("R7 window base", {31'd0, bad_base}, 32'd0);
    check("R1 fetch count", nfetch, 32'd5);
    check("R1 pc step 8", max_fetch, 32'h20);
  endtask

  task automatic t_alu();
    clear_all();
    prog[0]  = ins(8'h05, 8'h01, 16'h0, 32'hF0F0_1234);
    prog[1]  = ins(8'h05, 8'h02, 16'h0, 32'h0FF0_00FF);
    prog[2]  = ins(8'h0A, 8'h01, 16'h0002, 32'h0);
    prog[3]  = ins(8'h02, 8'h01, 16'h0100, 32'h0);
    prog[4]  = ins(8'h0B, 8'h03, 16'h0002, 32'hFFFF_0000);
    prog[5]  = ins(8'h02, 8'h03, 16'h0104, 32'h0);
    prog[6]  = ins(8'h05, 8'h04, 16'h0, 32'd10);
    prog[7]  = ins(8'h05, 8'h05, 16'h0, 32'd7);
    prog[8]  = ins(8'h0C, 8'h04, 16'h0005, 32'h0);
    prog[9]  = ins(8'h02, 8'h04, 16'h0108, 32'h0);
    prog[10] = ins(8'h0C, 8'h06, 16'h0005, 32'd4);
    prog[11] = ins(8'h02, 8'h06, 16'h010C, 32'h0);
    prog[12] = ins(8'h0D, 8'h04, 16'h0005, 32'h0);
    prog[13] = ins(8'h02, 8'h04, 16'h0110, 32'h0);
    prog[14] = ins(8'h0D, 8'h06, 16'h0004, 32'd3);
    prog[15] = ins(8'h02, 8'h06, 16'h0114, 32'h0);
    prog[16] = ins(8'h05, 8'h07, 16'h0, 32'd33);
    prog[17] = ins(8'h05, 8'h00, 16'h0, 32'd1);
    prog[18] = ins(8'h13, 8'h00, 16'h0007, 32'h0);
    prog[19] = ins(8'h02, 8'h00, 16'h0118, 32'h0);
    prog[20] = ins(8'h13, 8'h07, 16'h0000, 32'd4);
    prog[21] = ins(8'h02, 8'h07, 16'h011C, 32'h0);
    prog[22] = ins(8'h05, 8'h01, 16'h0, 32'h8000_0000);
    prog[23] = ins(8'h14, 8'h02, 16'h0001, 32'd4);
    prog[24] = ins(8'h02, 8'h02, 16'h0120, 32'h0);
    prog[25] = ins(8'h05, 8'h03, 16'h0, 32'd2);
    prog[26] = ins(8'h14, 8'h01, 16'h0003, 32'h0);
    prog[27] = ins(8'h02, 8'h01, 16'h0124, 32'h0);
    prog[28] = ins(8'h0B, 8'h05, 16'h0004, 32'h0);
    prog[29] = ins(8'h02, 8'h05, 16'h0128, 32'h0);
    prog[30] = ins(8'h0A, 8'h06, 16'h0003, 32'h0000_000F);
    prog[31] = ins(8'h02, 8'h06, 16'h012C, 32'h0);
    launch();
    finish_run("alu");
    check("R5 and reg-reg", wmem[32'h100 >> 2], 32'h00F0_0034);
    check("R5 or reg-imm", wmem[32'h104 >> 2], 32'hFFFF_00FF);
    check("R5 add reg-reg", wmem[32'h108 >> 2], 32'd17);
    check("R5 add reg-imm", wmem[32'h10C >> 2], 32'd11);
    check("R5 sub reg-reg", wmem[32'h110 >> 2], 32'd10);
    check("R5 sub reg-imm", wmem[32'h114 >> 2], 32'd7);
    check("R5 shl amount low 5 bits", wmem[32'h118 >> 2], 32'd2);
    check("R5 shl reg-imm", wmem[32'h11C >> 2], 32'd32);
    check("R5 shr logical reg-imm", wmem[32'h120 >> 2], 32'h0800_0000);
    check("R5 shr reg-reg", wmem[32'h124 >> 2], 32'h2000_0000);
    check("R5 or reg-reg", wmem[32'h128 >> 2], 32'hF);
    check("R5 and reg-imm", wmem[32'h12C >> 2], 32'd2);
  endtask

  task automatic t_jump();
    clear_all();
    prog[0]  = ins(8'h05, 8'h01, 16'h0, 32'd3);
    prog[1]  = ins(8'h05, 8'h02, 16'h0, 32'd0);
    prog[2]  = ins(8'h0C, 8'h02, 16'h0002, 32'd5);
    prog[3]  = ins(8'h0D, 8'h01, 16'h0001, 32'd1);
    prog[4]  = ins(8'h0E, 8'h01, 16'h0, 32'h10);
    prog[5]  = ins(8'h17, 8'h01, 16'h0, 32'h38);
    prog[6]  = ins(8'h05, 8'h02, 16'h0, 32'hDEAD);
    prog[7]  = ins(8'h02, 8'h02, 16'h0200, 32'h0);
    prog[8]  = ins(8'h05, 8'h03, 16'h0, 32'd1);
    prog[9]  = ins(8'h17, 8'h03, 16'h0, 32'h58);
    prog[10] = ins(8'h02, 8'h03, 16'h0204, 32'h0);
    launch();
    finish_run("jump");
    check("R6 nonzero loop and zero jump", wmem[32'h200 >> 2], 32'd15);
    check("R6 zero jump not taken", wmem[32'h204 >> 2], 32'd1);
  endtask

  task automatic t_window(input string tag);
    clear_all();
    wmem[32'hD08 >> 2] = 32'h1234_ABCD;
    prog[0] = ins(8'h04, 8'h07, 16'h0D08, 32'h0000_FFFF);
    prog[1] = ins(8'h02, 8'h07, 16'h0300, 32'h0);
    prog[2] = ins(8'h05, 8'h04, 16'h0, 32'hFFFF_0D08);
    prog[3] = ins(8'h18, 8'h02, 16'h0004, 32'h0);
    prog[4] = ins(8'h05, 8'h03, 16'h0, 32'h0000_0304);
    prog[5] = ins(8'h19, 8'h02, 16'h0003, 32'h0);
    launch();
    finish_run(tag);
    check({tag, " R7 masked load"}, wmem[32'h300 >> 2], 32'h0000_ABCD);
    check({tag, " R7 indirect load/store"}, wmem[32'h304 >> 2], 32'h1234_ABCD);
  endtask

  task automatic t_ram(input string tag);
    clear_all();
    rmem[4] = 32'hCAFE_F00D;
    prog[0] = ins(8'h05, 8'h01, 16'h0, 32'h0900_0010);
    prog[1] = ins(8'h03, 8'h00, 16'h0001, 32'h0);
    prog[2] = ins(8'h05, 8'h07, 16'h0, 32'h0900_0020);
    prog[3] = ins(8'h11, 8'h07, 16'h0000, 32'h0);
    launch();
    finish_run(tag);
    check({tag, " R8 ram load then store"}, rmem[8], 32'hCAFE_F00D);
    check({tag, " R8 ram pointer"}, last_ram_addr, 32'h0900_0020);
  endtask

  task automatic t_stall();
    stall = 4'd3;
    t_window("stall");
    t_ram("stall");
    check("R9 base under stall", {31'd0, bad_base}, 32'd0);
    stall = 4'd0;
  endtask

  task automatic t_wait();
    bit early = 0;
    clear_all();
    status = 8'h00;
    prog[0] = ins(8'h07, 8'h03, 16'h0, 32'h0);
    prog[1] = ins(8'h01, 8'h00, 16'h0400, 32'h55);
    launch();
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (done) early = 1; end
    status = 8'hF7;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (done) early = 1; end
    check("R10 stall holds busy", {31'd0, busy}, 32'd1);
    check("R10 other bits ignored", {31'd0, early}, 32'd0);
    check("R10 no progress while stalled", wmem[32'h400 >> 2], 32'd0);
    status = 8'h08;
    finish_run("wait");
    check("R10 resumes on selected bit", wmem[32'h400 >> 2], 32'h55);
    status = 8'h00;
  endtask

  task automatic t_undef();
    clear_all();
    prog[0] = ins(8'h01, 8'h00, 16'h0500, 32'd1);
    prog[1] = ins(8'h20, 8'h00, 16'h0, 32'h0);
    prog[2] = ins(8'h01, 8'h00, 16'h0504, 32'd2);
    launch();
    finish_run("undef");
    check("R11 error set", {31'd0, error}, 32'd1);
    check("R11 earlier store ran", wmem[32'h500 >> 2], 32'd1);
    check("R11 later store skipped", wmem[32'h504 >> 2], 32'd0);
    prog[1] = 64'd0;
    launch();
    check("R11 error cleared on start", {31'd0, error}, 32'd0);
    finish_run("undef-rerun");
    check("R11 clean run", {31'd0, error}, 32'd0);
  endtask

  initial begin
    clear_all();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_alu();
    t_jump();
    t_window("win");
    t_ram("ram");
    t_stall();
    t_wait();
    t_undef();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule